// File: doc/BRIEF.md
# Programmable Asynchronous SRAM Bus Controller

This block turns single requests from an internal master into the timed strobe sequence of an external asynchronous SRAM with a single bank. A request carries the direction, the address, the write data and the byte lane enables. It is accepted in a cycle where `ready` is high. The controller then runs a setup phase, an access phase and a hold phase. Each phase lasts a cycle count taken from the configuration inputs, and reads and writes have separate sets of counts.

Between accesses the controller can insert two gaps. An idle gap follows every hold phase. A turnaround gap is placed in front of a read whose previous access was a write, so that the data bus drivers are off before the memory starts to drive. All bus outputs come straight from flip-flops. Read data is latched at the end of the read access phase and returned with a one-cycle `done` pulse. The same pulse also marks the completion of a write.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `bus_cs_n`, `bus_oe_n`, `bus_we_n` and `bus_rs_n` are 1, `bus_doe` is 0, `bus_be_n` is all ones, `bus_addr` and `bus_dout` are 0, and `ready` is 1.
- R2: For a write, `bus_cs_n` is 0, `bus_doe` is 1, and `bus_addr`, `bus_dout` and `bus_be_n` (the inverted byte enables) are driven for the setup, access and hold cycles back to back. All of them return to the idle values in the first cycle after the hold phase.
- R3: `bus_we_n` is 0 exactly during the write access cycles and 1 during write setup and hold.
- R4: For a read, `bus_cs_n` and `bus_oe_n` go low together in the first read setup cycle and stay low through the read hold. `bus_rs_n` is 0 exactly during the read access cycles. `bus_doe` stays 0.
- R5: `bus_din` is sampled on the last read access cycle. In the following cycle `rd_data` holds that value and `done` is 1 for one cycle. A write also pulses `done` in the cycle after its last access cycle.
- R6: A setup, hold, turnaround or idle count of 0 removes that phase. An access count of 0 gives one access cycle.
- R7: When a read is accepted and the previous accepted request was a write, `cfg_turn` cycles with all strobes inactive come before the read setup. No such gap is inserted for read after read, write after write or write after read. After reset the previous request counts as a read.
- R8: After the hold phase (or after access, when hold is 0), `cfg_idle` cycles with an idle bus and `ready` low follow before `ready` returns to 1.
- R9: `ready` is 1 only while no access or gap is running. A request presented while `ready` is 0 has no effect on the bus or on the later sequence.
- R10: A request is accepted on the rising edge where `req_valid` and `ready` are both 1. The first cycle of its sequence, whether turnaround, setup or access, is the cycle right after that edge, and `ready` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_setup | input | CNT_W | Write setup cycles |
| cfg_wr_access | input | CNT_W | Write access cycles (0 counts as 1) |
| cfg_wr_hold | input | CNT_W | Write hold cycles |
| cfg_rd_setup | input | CNT_W | Read setup cycles |
| cfg_rd_access | input | CNT_W | Read access cycles (0 counts as 1) |
| cfg_rd_hold | input | CNT_W | Read hold cycles |
| cfg_turn | input | CNT_W | Write-to-read turnaround cycles |
| cfg_idle | input | CNT_W | Idle gap cycles after each access |
| req_valid | input | 1 | Request present |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte lane enables, active high |
| ready | output | 1 | Controller can accept a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_rs_n | output | 1 | Read strobe, active low |
| bus_addr | output | ADDR_W | Memory address |
| bus_dout | output | DATA_W | Data driven to the memory |
| bus_doe | output | 1 | Data driver enable, active high |
| bus_din | input | DATA_W | Data returned by the memory |
| bus_be_n | output | DATA_W/8 | Byte lane enables, active low |

## Verification
The hardest situation to reach is the turnaround gap. It appears only when a read follows a write, and only with certain phase counts. A read that is sampled one cycle early or late is also hard to see, because the memory data looks valid during the whole strobe. To reach the gap, the bench runs request lists that mix write-then-read, read-then-read, write-then-write and read-then-write under three timing sets, including all-zero counts. The memory model presents valid data only on the last cycle of the read strobe and a marker value on every other cycle. Every cycle in which `ready` is low also carries a stray request, so that any effect of an ignored request shows up in the per-cycle comparison.

// File: rtl/asram_pkg.sv
package asram_pkg;

   // Sequencer phases; the bus pin values are decoded from these.
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_TURN   = 3'd1,
      PH_SETUP  = 3'd2,
      PH_ACCESS = 3'd3,
      PH_HOLD   = 3'd4,
      PH_GAP    = 3'd5
   } phase_e;

endpackage

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int BE_W   = 2,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cfg_wr_setup,
   input  logic [CNT_W-1:0]  cfg_wr_access,
   input  logic [CNT_W-1:0]  cfg_wr_hold,
   input  logic [CNT_W-1:0]  cfg_rd_setup,
   input  logic [CNT_W-1:0]  cfg_rd_access,
   input  logic [CNT_W-1:0]  cfg_rd_hold,
   input  logic [CNT_W-1:0]  cfg_turn,
   input  logic [CNT_W-1:0]  cfg_idle,
   input  logic              req_valid,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [BE_W-1:0]   req_be,
   output logic              ready,
   output phase_e            nxt_phase,
   output logic              nxt_wr,
   output logic [ADDR_W-1:0] nxt_addr,
   output logic [DATA_W-1:0] nxt_wdata,
   output logic [BE_W-1:0]   nxt_be,
   output logic              acc_last,
   output logic              cur_wr
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   phase_e            phase_q;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic              wr_q, last_wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [BE_W-1:0]   be_q;

   logic              accept;
   logic              cnt_zero;
   logic [CNT_W-1:0]  su_len, ac_raw, ac_len, ho_len;

   assign ready    = (phase_q == PH_IDLE);
   assign accept   = req_valid && ready;
   assign cnt_zero = (cnt_q == '0);

   // Operation whose counts apply: a new request at acceptance, else the latched one
   assign nxt_wr    = accept ? req_wr    : wr_q;
   assign nxt_addr  = accept ? req_addr  : addr_q;
   assign nxt_wdata = accept ? req_wdata : wdata_q;
   assign nxt_be    = accept ? req_be    : be_q;

   assign su_len = nxt_wr ? cfg_wr_setup  : cfg_rd_setup;
   assign ac_raw = nxt_wr ? cfg_wr_access : cfg_rd_access;
   assign ho_len = nxt_wr ? cfg_wr_hold   : cfg_rd_hold;
   assign ac_len = (ac_raw == '0) ? CNT_ONE : ac_raw;

   assign acc_last = (phase_q == PH_ACCESS) && cnt_zero;
   assign cur_wr   = wr_q;

   always_comb begin
      nxt_phase = phase_q;
      cnt_d     = cnt_q;
      unique case (phase_q)
         PH_IDLE: begin
            if (accept) begin
               if (last_wr_q && !req_wr && (cfg_turn != '0)) begin
                  nxt_phase = PH_TURN;
                  cnt_d     = cfg_turn - CNT_ONE;
               end else if (su_len != '0) begin
                  nxt_phase = PH_SETUP;
                  cnt_d     = su_len - CNT_ONE;
               end else begin
                  nxt_phase = PH_ACCESS;
                  cnt_d     = ac_len - CNT_ONE;
               end
            end
         end
         PH_TURN: begin
            if (!cnt_zero) begin
               cnt_d = cnt_q - CNT_ONE;
            end else if (su_len != '0) begin
               nxt_phase = PH_SETUP;
               cnt_d     = su_len - CNT_ONE;
            end else begin
               nxt_phase = PH_ACCESS;
               cnt_d     = ac_len - CNT_ONE;
            end
         end
         PH_SETUP: begin
            if (!cnt_zero) begin
               cnt_d = cnt_q - CNT_ONE;
            end else begin
               nxt_phase = PH_ACCESS;
               cnt_d     = ac_len - CNT_ONE;
            end
         end
         PH_ACCESS: begin
            if (!cnt_zero) begin
               cnt_d = cnt_q - CNT_ONE;
            end else if (ho_len != '0) begin
               nxt_phase = PH_HOLD;
               cnt_d     = ho_len - CNT_ONE;
            end else if (cfg_idle != '0) begin
               nxt_phase = PH_GAP;
               cnt_d     = cfg_idle - CNT_ONE;
            end else begin
               nxt_phase = PH_IDLE;
               cnt_d     = '0;
            end
         end
         PH_HOLD: begin
            if (!cnt_zero) begin
               cnt_d = cnt_q - CNT_ONE;
            end else if (cfg_idle != '0) begin
               nxt_phase = PH_GAP;
               cnt_d     = cfg_idle - CNT_ONE;
            end else begin
               nxt_phase = PH_IDLE;
               cnt_d     = '0;
            end
         end
         PH_GAP: begin
            if (!cnt_zero) begin
               cnt_d = cnt_q - CNT_ONE;
            end else begin
               nxt_phase = PH_IDLE;
               cnt_d     = '0;
            end
         end
         default: begin
            nxt_phase = PH_IDLE;
            cnt_d     = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         cnt_q     <= '0;
         wr_q      <= 1'b0;
         last_wr_q <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
         be_q      <= '0;
      end else begin
         phase_q <= nxt_phase;
         cnt_q   <= cnt_d;
         if (accept) begin
            wr_q      <= req_wr;
            last_wr_q <= req_wr;
            addr_q    <= req_addr;
            wdata_q   <= req_wdata;
            be_q      <= req_be;
         end
      end
   end

endmodule

// File: rtl/asram_drv.sv
module asram_drv
   import asram_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int DATA_W         = 16,
   parameter int BE_W           = 2,
   parameter bit CLEAR_IDLE_BUS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            nxt_phase,
   input  logic              nxt_wr,
   input  logic [ADDR_W-1:0] nxt_addr,
   input  logic [DATA_W-1:0] nxt_wdata,
   input  logic [BE_W-1:0]   nxt_be,
   output logic              bus_cs_n,
   output logic              bus_oe_n,
   output logic              bus_we_n,
   output logic              bus_rs_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   output logic [BE_W-1:0]   bus_be_n
);

   logic              act;
   logic              in_acc;
   logic [ADDR_W-1:0] addr_v;
   logic [DATA_W-1:0] dout_v;

   assign act    = (nxt_phase == PH_SETUP) || (nxt_phase == PH_ACCESS) ||
                   (nxt_phase == PH_HOLD);
   assign in_acc = (nxt_phase == PH_ACCESS);

   // Variant: park address/data at zero, or keep the last driven value
   if (CLEAR_IDLE_BUS) begin : g_clear
      assign addr_v = act ? nxt_addr : '0;
      assign dout_v = (act && nxt_wr) ? nxt_wdata : '0;
   end else begin : g_keep
      assign addr_v = act ? nxt_addr : bus_addr;
      assign dout_v = (act && nxt_wr) ? nxt_wdata : bus_dout;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_cs_n <= 1'b1;
         bus_oe_n <= 1'b1;
         bus_we_n <= 1'b1;
         bus_rs_n <= 1'b1;
         bus_doe  <= 1'b0;
         bus_addr <= '0;
         bus_dout <= '0;
      end else begin
         bus_cs_n <= !act;
         bus_oe_n <= !(act && !nxt_wr);
         bus_we_n <= !(in_acc && nxt_wr);
         bus_rs_n <= !(in_acc && !nxt_wr);
         bus_doe  <= act && nxt_wr;
         bus_addr <= addr_v;
         bus_dout <= dout_v;
      end
   end

   for (genvar i = 0; i < BE_W; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bus_be_n[i] <= 1'b1;
         else        bus_be_n[i] <= !(act && nxt_be[i]);
      end
   end

endmodule

// File: rtl/asram_rdcap.sv
module asram_rdcap #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_last,
   input  logic              cur_wr,
   input  logic [DATA_W-1:0] bus_din,
   output logic              done,
   output logic [DATA_W-1:0] rd_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done    <= 1'b0;
         rd_data <= '0;
      end else begin
         done <= acc_last;
         if (acc_last && !cur_wr) rd_data <= bus_din;
      end
   end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int DATA_W         = 16,
   parameter int CNT_W          = 4,
   parameter bit CLEAR_IDLE_BUS = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [CNT_W-1:0]      cfg_wr_setup,
   input  logic [CNT_W-1:0]      cfg_wr_access,
   input  logic [CNT_W-1:0]      cfg_wr_hold,
   input  logic [CNT_W-1:0]      cfg_rd_setup,
   input  logic [CNT_W-1:0]      cfg_rd_access,
   input  logic [CNT_W-1:0]      cfg_rd_hold,
   input  logic [CNT_W-1:0]      cfg_turn,
   input  logic [CNT_W-1:0]      cfg_idle,
   input  logic                  req_valid,
   input  logic                  req_wr,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [DATA_W/8-1:0]   req_be,
   output logic                  ready,
   output logic                  done,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  bus_cs_n,
   output logic                  bus_oe_n,
   output logic                  bus_we_n,
   output logic                  bus_rs_n,
   output logic [ADDR_W-1:0]     bus_addr,
   output logic [DATA_W-1:0]     bus_dout,
   output logic                  bus_doe,
   input  logic [DATA_W-1:0]     bus_din,
   output logic [DATA_W/8-1:0]   bus_be_n
);

   localparam int BE_W = DATA_W / 8;

   if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data_w
      $error("asram_ctrl: DATA_W must be a positive multiple of 8");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
      $error("asram_ctrl: CNT_W must lie in 1..16");
   end
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("asram_ctrl: ADDR_W must be at least 1");
   end

   phase_e            nxt_phase;
   logic              nxt_wr;
   logic [ADDR_W-1:0] nxt_addr;
   logic [DATA_W-1:0] nxt_wdata;
   logic [BE_W-1:0]   nxt_be;
   logic              acc_last;
   logic              cur_wr;

   asram_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_setup(cfg_wr_setup), .cfg_wr_access(cfg_wr_access),
      .cfg_wr_hold(cfg_wr_hold), .cfg_rd_setup(cfg_rd_setup),
      .cfg_rd_access(cfg_rd_access), .cfg_rd_hold(cfg_rd_hold),
      .cfg_turn(cfg_turn), .cfg_idle(cfg_idle),
      .req_valid(req_valid), .req_wr(req_wr), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be),
      .ready(ready),
      .nxt_phase(nxt_phase), .nxt_wr(nxt_wr), .nxt_addr(nxt_addr),
      .nxt_wdata(nxt_wdata), .nxt_be(nxt_be),
      .acc_last(acc_last), .cur_wr(cur_wr)
   );

   asram_drv #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W),
      .CLEAR_IDLE_BUS(CLEAR_IDLE_BUS)
   ) u_drv (
      .clk(clk), .rst_n(rst_n),
      .nxt_phase(nxt_phase), .nxt_wr(nxt_wr), .nxt_addr(nxt_addr),
      .nxt_wdata(nxt_wdata), .nxt_be(nxt_be),
      .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
      .bus_rs_n(bus_rs_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
      .bus_doe(bus_doe), .bus_be_n(bus_be_n)
   );

   asram_rdcap #(
      .DATA_W(DATA_W)
   ) u_cap (
      .clk(clk), .rst_n(rst_n),
      .acc_last(acc_last), .cur_wr(cur_wr), .bus_din(bus_din),
      .done(done), .rd_data(rd_data)
   );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic ready,
   input logic done,
   input logic bus_cs_n,
   input logic bus_oe_n,
   input logic bus_we_n,
   input logic bus_rs_n,
   input logic bus_doe
);

   p_we_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we_n |-> (!bus_cs_n && bus_oe_n && bus_doe));

   p_rs_with_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rs_n |-> (!bus_oe_n && !bus_cs_n && !bus_doe));

   p_oe_with_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_oe_n) |-> $fell(bus_cs_n));

   p_doe_in_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_doe |-> (!bus_cs_n && bus_oe_n));

   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_ready_bus_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (bus_cs_n && bus_oe_n && bus_we_n && bus_rs_n && !bus_doe));

   p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ready) |=> !ready);

endmodule

bind asram_ctrl asram_ctrl_chk u_chk (.*);

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;

   localparam int AW = 16;
   localparam int DW = 16;
   localparam int BW = 2;
   localparam int CW = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic          rst_n = 1'b0;
   logic [CW-1:0] cfg_wr_setup, cfg_wr_access, cfg_wr_hold;
   logic [CW-1:0] cfg_rd_setup, cfg_rd_access, cfg_rd_hold;
   logic [CW-1:0] cfg_turn, cfg_idle;
   logic          req_valid = 1'b0, req_wr = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [BW-1:0] req_be = '0;
   logic          ready, done;
   logic [DW-1:0] rd_data;
   logic          bus_cs_n, bus_oe_n, bus_we_n, bus_rs_n, bus_doe;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_dout, bus_din;
   logic [BW-1:0] bus_be_n;

   asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_setup(cfg_wr_setup), .cfg_wr_access(cfg_wr_access),
      .cfg_wr_hold(cfg_wr_hold), .cfg_rd_setup(cfg_rd_setup),
      .cfg_rd_access(cfg_rd_access), .cfg_rd_hold(cfg_rd_hold),
      .cfg_turn(cfg_turn), .cfg_idle(cfg_idle),
      .req_valid(req_valid), .req_wr(req_wr), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be),
      .ready(ready), .done(done), .rd_data(rd_data),
      .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
      .bus_rs_n(bus_rs_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
      .bus_doe(bus_doe), .bus_din(bus_din), .bus_be_n(bus_be_n)
   );

   // Memory model: valid data only on the final cycle of the read strobe
   int rs_cnt = 0;
   always @(posedge clk) rs_cnt <= bus_rs_n ? 0 : rs_cnt + 1;
   int rd_acc_eff;
   assign rd_acc_eff = (cfg_rd_access == 0) ? 1 : int'(cfg_rd_access);
   assign bus_din = (!bus_rs_n && rs_cnt == rd_acc_eff - 1) ?
                    (bus_addr ^ 16'h5A3C) : 16'hDEAD;

   typedef struct packed {
      logic cs, oe, we, rs, doe, rdy, dn, rdchk;
      logic [AW-1:0] addr;
      logic [DW-1:0] dout, rdv;
      logic [BW-1:0] be_n;
   } ent_t;

   typedef struct packed {
      logic wr;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic [BW-1:0] be;
   } rq_t;

   ent_t mq[$];
   rq_t  rq[$];
   logic last_wr = 1'b0;
   int   checks = 0, fails = 0;

   function automatic ent_t idle_e(bit rdy);
      ent_t e;
      e = '0;
      e.cs = 1; e.oe = 1; e.we = 1; e.rs = 1;
      e.rdy = rdy; e.be_n = '1;
      return e;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Expected per-cycle trace of one accepted request
   task automatic build(rq_t r);
      ent_t e, t;
      int su, ac, ho, mark;
      su = r.wr ? int'(cfg_wr_setup)  : int'(cfg_rd_setup);
      ac = r.wr ? int'(cfg_wr_access) : int'(cfg_rd_access);
      ho = r.wr ? int'(cfg_wr_hold)   : int'(cfg_rd_hold);
      if (ac == 0) ac = 1;
      if (last_wr && !r.wr) repeat (int'(cfg_turn)) mq.push_back(idle_e(0));
      last_wr = r.wr;
      e = idle_e(0);
      e.cs = 0; e.oe = r.wr; e.doe = r.wr; e.addr = r.addr;
      e.dout = r.wr ? r.data : '0; e.be_n = ~r.be;
      repeat (su) mq.push_back(e);
      e.we = !r.wr; e.rs = r.wr;
      repeat (ac) mq.push_back(e);
      mark = mq.size();
      e.we = 1; e.rs = 1;
      repeat (ho) mq.push_back(e);
      repeat (int'(cfg_idle)) mq.push_back(idle_e(0));
      mq.push_back(idle_e(1));
      t = mq[mark]; t.dn = 1; t.rdchk = !r.wr; t.rdv = r.addr ^ 16'h5A3C;
      mq[mark] = t;
   endtask

   task automatic drain();
      ent_t e;
      rq_t  r;
      forever begin
         @(negedge clk);
         e = (mq.size() > 0) ? mq.pop_front() : idle_e(1);
         chk("R2 cs_n", 32'(bus_cs_n), 32'(e.cs));
         chk("R4 oe_n", 32'(bus_oe_n), 32'(e.oe));
         chk("R3 we_n", 32'(bus_we_n), 32'(e.we));
         chk("R4 rs_n", 32'(bus_rs_n), 32'(e.rs));
         chk("R2 doe",  32'(bus_doe),  32'(e.doe));
         chk("R2 addr", 32'(bus_addr), 32'(e.addr));
         chk("R2 dout", 32'(bus_dout), 32'(e.dout));
         chk("R2 be_n", 32'(bus_be_n), 32'(e.be_n));
         chk("R9 ready", 32'(ready), 32'(e.rdy));
         chk("R5 done", 32'(done), 32'(e.dn));
         if (e.rdchk) chk("R5 rd_data", 32'(rd_data), 32'(e.rdv));
         if (e.rdy) begin
            if (rq.size() > 0) begin
               r = rq.pop_front();
               req_valid = 1; req_wr = r.wr; req_addr = r.addr;
               req_wdata = r.data; req_be = r.be;
               build(r);       // R10: trace starts the cycle after acceptance
            end else begin
               req_valid = 0;
               return;
            end
         end else begin
            // R9: stray request while busy must leave the trace unchanged
            req_valid = 1; req_wr = ~req_wr; req_addr = 16'hBEEF;
            req_wdata = 16'hF00D; req_be = 2'b11;
         end
      end
   endtask

   function automatic rq_t mk(bit wr, logic [15:0] a, logic [15:0] d, logic [1:0] be);
      rq_t r;
      r.wr = wr; r.addr = a; r.data = d; r.be = be;
      return r;
   endfunction

   task automatic set_cfg(int ws, int wa, int wh, int rs, int ra, int rh, int tn, int id);
      cfg_wr_setup = CW'(ws); cfg_wr_access = CW'(wa); cfg_wr_hold = CW'(wh);
      cfg_rd_setup = CW'(rs); cfg_rd_access = CW'(ra); cfg_rd_hold = CW'(rh);
      cfg_turn = CW'(tn); cfg_idle = CW'(id);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      set_cfg(2, 4, 2, 3, 5, 1, 2, 0);
      repeat (2) @(negedge clk);
      // R1: outputs during reset
      chk("R1 cs_n", 32'(bus_cs_n), 1);
      chk("R1 we_n", 32'(bus_we_n), 1);
      chk("R1 oe_n", 32'(bus_oe_n), 1);
      chk("R1 rs_n", 32'(bus_rs_n), 1);
      chk("R1 doe", 32'(bus_doe), 0);
      chk("R1 be_n", 32'(bus_be_n), 32'h3);
      chk("R1 ready", 32'(ready), 1);
      chk("R1 addr", 32'(bus_addr), 0);
      rst_n = 1'b1;

      // Timing set A: mixed order, turnaround of 2 (R7), no idle gap
      rq.push_back(mk(1, 16'h0100, 16'h1234, 2'b11));
      rq.push_back(mk(0, 16'h0200, 16'h0, 2'b11));
      rq.push_back(mk(0, 16'h0201, 16'h0, 2'b01));
      rq.push_back(mk(1, 16'h0300, 16'hABCD, 2'b10));
      rq.push_back(mk(1, 16'h0301, 16'h5555, 2'b01));
      rq.push_back(mk(0, 16'h0400, 16'h0, 2'b11));
      drain();

      // Timing set B: zero counts skip phases, access 0 -> 1 (R6), idle gap 3 (R8)
      set_cfg(0, 0, 0, 0, 0, 0, 0, 3);
      rq.push_back(mk(1, 16'h1000, 16'h0F0F, 2'b11));
      rq.push_back(mk(0, 16'h1001, 16'h0, 2'b11));
      rq.push_back(mk(1, 16'h1002, 16'hC3C3, 2'b10));
      rq.push_back(mk(0, 16'h1003, 16'h0, 2'b01));
      drain();

      // Timing set C: long turnaround, read hold, idle 1 (R7, R8)
      set_cfg(1, 1, 0, 0, 2, 3, 5, 1);
      rq.push_back(mk(0, 16'h2000, 16'h0, 2'b11));
      rq.push_back(mk(1, 16'h2001, 16'h7777, 2'b11));
      rq.push_back(mk(0, 16'h2002, 16'h0, 2'b11));
      rq.push_back(mk(1, 16'h2003, 16'h8888, 2'b01));
      rq.push_back(mk(1, 16'h2004, 16'h9999, 2'b10));
      rq.push_back(mk(0, 16'hFFFF, 16'h0, 2'b11));
      drain();

      repeat (3) @(negedge clk);
      chk("R9 ready idle", 32'(ready), 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule